// File: doc/BRIEF.md
# eFuse Bit-Programming Sequencer

This block burns a short byte buffer into a one-time-programmable fuse array by driving the array's control word directly. A host presents a starting byte offset, a byte count and a packed data buffer, then pulses `start_i`. The sequencer raises `busy_o` and walks the buffer from the lowest bit upwards. For each set bit it emits a program-mode control word that carries the fuse address. After a setup interval it adds a timed strobe, then removes the strobe and holds the word before it moves on. Cleared bits get no strobe at all, because a fuse can never return to the unset state.

Once the last set bit is finished, the sequencer drives the standby word and pulses `done_o`. All intervals are derived from a ticks-per-microsecond parameter: the setup is 1 us, the strobe 15 us and the hold 1 us. The address field is masked to the array width and placed at a parameterised position in the control word. Read access, supply sequencing and clock gating belong to other blocks.

Top module: `fuse_burn_seq`

## Requirements
- R1: Out of reset, `fuse_ctrl_o` equals the standby word 0x00000021 (power-down bit 5 and chip-select-bar bit 0 high, all else low), and `busy_o` and `done_o` are low.
- R2: While a fuse is being burned, the word has program-select (bit 4) and strobe-select (bit 9) high, and chip-select-bar (bit 0), load (bit 2), program-enable-bar (bit 3), power-down (bit 5) and read-sense-bar (bit 7) low. With the default parameters, bits [25:16] carry the fuse address (offset*8 + bit index) mod 1024.
- R3: Each strobe pulse (bit 1) burns exactly one fuse. The whole word stays constant while the strobe is high, and the number of strobes equals the number of set bits in the counted bytes.
- R4: Data bits that are zero produce no strobe. The array contents after an operation are the OR of the previous contents and the written data.
- R5: Fuses are strobed in strictly ascending address order, bit 0 of each byte first.
- R6: For each set bit, the address word without strobe lasts exactly SETUP_US*TICKS_PER_US cycles. The strobe then lasts exactly STROBE_US*TICKS_PER_US cycles, and the word without strobe is held for at least HOLD_US*TICKS_PER_US cycles before it changes.
- R7: After the last bit, `fuse_ctrl_o` returns to the standby word. In the same cycle `done_o` pulses high for exactly one cycle and `busy_o` falls.
- R8: A `start_i` pulse while `busy_o` is high is ignored: it burns nothing and starts no new operation.
- R9: A byte count of zero drives standby and pulses `done_o` two cycles after the start is sampled, with no strobe.
- R10: Bytes of `data_i` at or beyond the byte count are never burned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| offset_i | input | OFF_W | Byte offset of the first byte in the array |
| count_i | input | CNT_W | Number of bytes to burn |
| data_i | input | BUF_BYTES*8 | Packed data buffer, byte 0 in bits [7:0] |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at the return to standby |
| fuse_ctrl_o | output | CTRL_W | Control word to the fuse array |

## Verification
Two events can meet in the same cycle. One is the acceptance logic for `start_i`. The other is the strobe path, which is at that moment burning a fuse. The bench provokes this by pulsing a new start request exactly while a strobe is high. It then judges the outcome at the ports: the array model must show only the first buffer, the strobe count must match that buffer alone, and `busy_o` must stay low after `done_o`. A second overlap is a strobe that hits a fuse that is already set, in a later operation. The model has to keep that bit sticky, and the bench compares the whole array against its own OR-accumulated copy.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  // Control-word bit positions; the fuse array decodes these.
  localparam int unsigned B_CSB    = 0;
  localparam int unsigned B_STROBE = 1;
  localparam int unsigned B_LOAD   = 2;
  localparam int unsigned B_PGENB  = 3;
  localparam int unsigned B_PS     = 4;
  localparam int unsigned B_PD     = 5;
  localparam int unsigned B_RSB    = 7;
  localparam int unsigned B_SFTSEL = 9;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SCAN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/fuse_bit_walker.sv
// Finds the lowest set bit at or above the cursor and below the limit.
module fuse_bit_walker #(
  parameter int NBITS = 32,
  parameter int CUR_W = 6
) (
  input  logic [NBITS-1:0] bits_i,
  input  logic [CUR_W-1:0] cursor_i,
  input  logic [CUR_W-1:0] limit_i,
  output logic             found_o,
  output logic [CUR_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int j = NBITS - 1; j >= 0; j--) begin
      if (bits_i[j] && (CUR_W'(j) >= cursor_i) && (CUR_W'(j) < limit_i)) begin
        found_o = 1'b1;
        idx_o   = CUR_W'(j);
      end
    end
  end
endmodule

// File: rtl/fuse_phase_timer.sv
// Counts cycles inside a phase; last_o marks the final cycle of len_i.
module fuse_phase_timer #(
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [TMR_W-1:0] len_i,
  output logic             last_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == len_i - 1'b1);
endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
  import fuse_seq_pkg::*;
#(
  parameter int TICKS_PER_US = 100,
  parameter int SETUP_US     = 1,
  parameter int STROBE_US    = 15,
  parameter int HOLD_US      = 1,
  parameter int BUF_BYTES    = 4,
  parameter int OFF_W        = 8,
  parameter int ADDR_W       = 10,
  parameter int ADDR_SHIFT   = 16,
  parameter int CTRL_W       = 32,
  parameter int CNT_W        = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [OFF_W-1:0]       offset_i,
  input  logic [CNT_W-1:0]       count_i,
  input  logic [BUF_BYTES*8-1:0] data_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [CTRL_W-1:0]      fuse_ctrl_o
);
  localparam int NBITS   = BUF_BYTES * 8;
  localparam int CUR_W   = $clog2(NBITS + 1);
  localparam int S_CYC   = SETUP_US * TICKS_PER_US;
  localparam int STB_CYC = STROBE_US * TICKS_PER_US;
  localparam int H_CYC   = HOLD_US * TICKS_PER_US;
  localparam int TMR_W   = $clog2(S_CYC + STB_CYC + H_CYC + 1);

  // ---- arithmetic helpers ----
  function automatic logic [CTRL_W-1:0] standby_word();
    logic [CTRL_W-1:0] w;
    w         = '0;
    w[B_PD]   = 1'b1;
    w[B_CSB]  = 1'b1;
    return w;
  endfunction

  function automatic logic [CTRL_W-1:0] program_word(input logic [ADDR_W-1:0] a);
    logic [CTRL_W-1:0] w;
    w                        = '0;
    w[B_PS]                  = 1'b1;
    w[B_SFTSEL]              = 1'b1;
    w[ADDR_SHIFT +: ADDR_W]  = a;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] fuse_addr(input logic [OFF_W-1:0] off,
                                                  input logic [CUR_W-1:0] bit_i);
    logic [31:0] a;
    a = 32'(off) * 32'd8 + 32'(bit_i);
    return a[ADDR_W-1:0];
  endfunction

  function automatic logic [CUR_W-1:0] bit_limit(input logic [CNT_W-1:0] n);
    int t;
    t = int'(n) * 8;
    if (t > NBITS) t = NBITS;
    return CUR_W'(t);
  endfunction

  // ---- state ----
  phase_e             phase_q;
  logic [CUR_W-1:0]   cur_q;
  logic [OFF_W-1:0]   off_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NBITS-1:0]   data_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               done_q;

  // ---- named internal events ----
  logic               bit_found;
  logic [CUR_W-1:0]   bit_idx;
  logic               tmr_last;
  logic               tmr_clr;
  logic [TMR_W-1:0]   tmr_len;
  logic               start_take;
  logic               burn_rise;
  logic               burn_fall;
  logic               seq_finish;

  fuse_bit_walker #(.NBITS(NBITS), .CUR_W(CUR_W)) u_walker (
    .bits_i   (data_q),
    .cursor_i (cur_q),
    .limit_i  (bit_limit(cnt_q)),
    .found_o  (bit_found),
    .idx_o    (bit_idx)
  );

  always_comb begin
    case (phase_q)
      PH_SETUP:  tmr_len = TMR_W'(S_CYC);
      PH_STROBE: tmr_len = TMR_W'(STB_CYC);
      PH_HOLD:   tmr_len = TMR_W'(H_CYC);
      default:   tmr_len = TMR_W'(1);
    endcase
  end

  assign tmr_clr = (phase_q == PH_IDLE) || (phase_q == PH_SCAN) || tmr_last;

  fuse_phase_timer #(.TMR_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmr_clr),
    .len_i  (tmr_len),
    .last_o (tmr_last)
  );

  assign start_take = (phase_q == PH_IDLE) && start_i;
  assign burn_rise  = (phase_q == PH_SETUP) && tmr_last;
  assign burn_fall  = (phase_q == PH_STROBE) && tmr_last;
  assign seq_finish = (phase_q == PH_SCAN) && !bit_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cur_q   <= '0;
      off_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      ctrl_q  <= standby_word();
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_take) begin
          off_q   <= offset_i;
          cnt_q   <= count_i;
          data_q  <= data_i;
          cur_q   <= '0;
          phase_q <= PH_SCAN;
        end
        PH_SCAN: if (seq_finish) begin
          ctrl_q  <= standby_word();
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end else begin
          cur_q   <= bit_idx;
          ctrl_q  <= program_word(fuse_addr(off_q, bit_idx));
          phase_q <= PH_SETUP;
        end
        PH_SETUP: if (burn_rise) begin
          ctrl_q[B_STROBE] <= 1'b1;
          phase_q          <= PH_STROBE;
        end
        PH_STROBE: if (burn_fall) begin
          ctrl_q[B_STROBE] <= 1'b0;
          phase_q          <= PH_HOLD;
        end
        PH_HOLD: if (tmr_last) begin
          cur_q   <= cur_q + 1'b1;
          phase_q <= PH_SCAN;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign done_o      = done_q;
  assign fuse_ctrl_o = ctrl_q;

  // ---- assertion-only observers ----
  logic [CTRL_W-1:0] word_prev_q;
  logic [31:0]       word_run_q;
  logic [31:0]       stb_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_prev_q <= standby_word();
      word_run_q  <= '0;
      stb_run_q   <= '0;
    end else begin
      word_prev_q <= ctrl_q;
      if (ctrl_q != word_prev_q)   word_run_q <= 32'd1;
      else if (word_run_q != '1)   word_run_q <= word_run_q + 1'b1;
      if (ctrl_q[B_STROBE])        stb_run_q  <= stb_run_q + 1'b1;
      else                         stb_run_q  <= '0;
    end
  end

  // R2: program pattern whenever the strobe is driven
  a_r2_program_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_STROBE] |-> (ctrl_q[B_PS] && ctrl_q[B_SFTSEL] && !ctrl_q[B_CSB] &&
                          !ctrl_q[B_PGENB] && !ctrl_q[B_PD] && !ctrl_q[B_LOAD] &&
                          !ctrl_q[B_RSB]));

  // R3: word frozen while strobe stays high
  a_r3_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_STROBE] && $past(ctrl_q[B_STROBE])) |-> $stable(ctrl_q));

  // R6: strobe width and setup width in cycles
  a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[B_STROBE]) |-> (stb_run_q == STB_CYC));

  a_r6_setup_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[B_STROBE]) |-> (word_run_q == S_CYC));

  // R7: done coincides with standby and idle, one cycle only
  a_r7_done_standby: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fuse_ctrl_o == standby_word() && !busy_o));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: a strobe only appears inside an operation
  a_r8_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_STROBE] |-> busy_o);
endmodule

// File: tb/fuse_burn_seq_bench.sv
module fuse_burn_seq_bench;
  localparam int TPU   = 4;
  localparam int S_C   = 1 * TPU;
  localparam int STB_C = 15 * TPU;
  localparam int H_C   = 1 * TPU;
  localparam int ASZ   = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  offset_i = '0;
  logic [2:0]  count_i = '0;
  logic [31:0] data_i = '0;
  logic        busy_o, done_o;
  logic [31:0] fuse_ctrl_o;

  always #5 clk = ~clk;

  fuse_burn_seq #(.TICKS_PER_US(TPU)) u_fuse_burn_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
    .count_i(count_i), .data_i(data_i), .busy_o(busy_o), .done_o(done_o),
    .fuse_ctrl_o(fuse_ctrl_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---- fuse array model and monitor ----
  bit fuse_mem [ASZ];
  bit exp_mem  [ASZ];
  logic [31:0] prev_ctrl = 32'h21;
  int run = 0;
  int strobe_cnt = 0, pat_err = 0, tmg_err = 0, ord_err = 0;
  int last_addr = -1;
  int cur_addr = 0;
  bit after_fall = 0;

  function automatic bit pgm_ok(input logic [31:0] c);
    return c[4] && c[9] && !c[0] && !c[2] && !c[3] && !c[5] && !c[7];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (fuse_ctrl_o != prev_ctrl) begin
        if (fuse_ctrl_o[1] && !prev_ctrl[1]) begin
          if (run != S_C) tmg_err++;
          if (!pgm_ok(fuse_ctrl_o)) pat_err++;
          cur_addr = int'(fuse_ctrl_o[25:16]);
          if (cur_addr <= last_addr) ord_err++;
          last_addr = cur_addr;
        end else if (!fuse_ctrl_o[1] && prev_ctrl[1]) begin
          if (run >= STB_C && pgm_ok(prev_ctrl)) fuse_mem[cur_addr] = 1'b1;
          if (run != STB_C || fuse_ctrl_o != (prev_ctrl & ~32'h2)) tmg_err++;
          strobe_cnt++;
          after_fall = 1'b1;
        end else begin
          if (after_fall && run < H_C) tmg_err++;
          after_fall = 1'b0;
        end
        run = 1;
      end else begin
        run++;
      end
      prev_ctrl = fuse_ctrl_o;
    end
  end

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic launch(input logic [7:0] off, input logic [2:0] cnt, input logic [31:0] d);
    @(negedge clk);
    offset_i = off; count_i = cnt; data_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  function automatic int mem_mismatch();
    int m = 0;
    for (int a = 0; a < ASZ; a++) if (fuse_mem[a] != exp_mem[a]) m++;
    return m;
  endfunction

  // ---- stimulus table: {offset, count, data} ----
  localparam int NV = 6;
  localparam logic [42:0] VEC [NV] = '{
    {8'd0,   3'd1, 32'h0000_0081},
    {8'd2,   3'd2, 32'h0000_A501},
    {8'd5,   3'd4, 32'hF0F0_0F0F},
    {8'd0,   3'd1, 32'h0000_0003},
    {8'd20,  3'd2, 32'hFFFF_FF00},
    {8'd100, 3'd3, 32'h5A80_0001}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cyc, exp_n;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(fuse_ctrl_o == 32'h21, "R1 standby in reset", int'(fuse_ctrl_o), 32'h21);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(fuse_ctrl_o == 32'h21 && !busy_o && !done_o, "R1 idle after reset",
          int'({busy_o, done_o}), 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0]  off;
      logic [2:0]  cnt;
      logic [31:0] d;
      {off, cnt, d} = VEC[v];
      exp_n = 0;
      for (int j = 0; j < int'(cnt) * 8; j++) if (d[j]) begin
        exp_mem[int'(off) * 8 + j] = 1'b1;
        exp_n++;
      end
      strobe_cnt = 0; last_addr = -1; pat_err = 0; tmg_err = 0; ord_err = 0;
      launch(off, cnt, d);
      wait_done(cyc);
      check(done_o && fuse_ctrl_o == 32'h21 && !busy_o, "R7 standby with done",
            int'(fuse_ctrl_o), 32'h21);
      @(negedge clk);
      check(!done_o, "R7 done one cycle", int'(done_o), 0);
      check(mem_mismatch() == 0, "R4 R10 array equals OR of data", mem_mismatch(), 0);
      check(strobe_cnt == exp_n, "R3 one strobe per set bit", strobe_cnt, exp_n);
      check(pat_err == 0, "R2 program pattern", pat_err, 0);
      check(ord_err == 0, "R5 ascending order", ord_err, 0);
      check(tmg_err == 0, "R6 setup strobe hold cycles", tmg_err, 0);
    end

    // R9 zero byte count
    strobe_cnt = 0;
    launch(8'd10, 3'd0, 32'hFFFF_FFFF);
    check(busy_o && !done_o, "R9 busy one cycle after start", int'(busy_o), 1);
    @(negedge clk);
    check(done_o && fuse_ctrl_o == 32'h21, "R9 done after two cycles", int'(done_o), 1);
    check(strobe_cnt == 0 && mem_mismatch() == 0, "R9 no strobe", strobe_cnt, 0);

    // R8 start during a live strobe is ignored
    strobe_cnt = 0; last_addr = -1;
    exp_mem[60 * 8 + 0] = 1'b1;
    exp_mem[60 * 8 + 4] = 1'b1;
    launch(8'd60, 3'd1, 32'h0000_0011);
    cyc = 0;
    while (!fuse_ctrl_o[1] && cyc < 1000) begin @(negedge clk); cyc++; end
    offset_i = 8'd90; count_i = 3'd1; data_i = 32'hFF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(cyc);
    @(negedge clk);
    check(!busy_o, "R8 no second operation", int'(busy_o), 0);
    check(strobe_cnt == 2, "R8 strobes of first request only", strobe_cnt, 2);
    check(mem_mismatch() == 0, "R8 ignored data not burned", mem_mismatch(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule